// File: doc/BRIEF.md
# Real-Time Seconds and Fraction Counter

This block keeps wall-clock time from a 32768 Hz reference clock. A prescaler and a 12-bit fraction chain divide the reference down to 4096 steps per second. When the fraction chain rolls over, a 32-bit seconds counter advances. Software sees the upper eight bits of the fraction chain as a 256 Hz fraction field. Put together with the seconds count, that field gives a 40-bit time value in units of 1/256 second.

Every reference edge is carried into the host clock domain by a toggle synchroniser. All counters live in the host domain and advance once per synchronised reference update. A plain synchronous register port gives access to three words:

- the seconds count;
- the fraction field;
- a status word with a busy flag and a ready flag.

Busy means an update or a load is on its way. Ready opens a short window after each update in which a read is known to be safe. Reading the seconds word also copies the fraction field into a shadow, so the next fraction read belongs to the same instant. Writes to either count are held pending and applied together with the next reference update.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, the seconds word reads 0, the fraction word reads 0, and the status word reads 0 (busy and ready both low).
- R2: The fraction chain advances once every 8 reference rising edges. The fraction field, which is chain bits 11..4, therefore advances once every 128 reference edges, and the seconds count advances once every 32768 reference edges.
- R3: The fraction chain wraps from 4095 to 0 in the same update in which the seconds count increments. A coherent read pair never shows the old seconds value with fraction 0, nor the new seconds value with fraction 0xFF.
- R4: Register offsets are 0x0 for seconds (32 bits), 0x4 for the fraction field (bits 7:0, with bits 31:8 reading 0) and 0x8 for status (bit 0 busy, bit 1 ready, other bits 0). Any other offset reads 0. Read data appears in the cycle after rd_en.
- R5: A write to offset 0x0 loads the seconds count at the next reference update, and busy reads 1 from the cycle after the write until the load has been applied.
- R6: A write to offset 0x4 loads wdata[7:0] into chain bits 11..4 at the next reference update and clears the lower chain bits and the prescaler. The seconds count is left unchanged.
- R7: A read of offset 0x0 captures the current fraction field into a shadow. The next read of offset 0x4 returns the shadow and releases it. A read of offset 0x4 with no shadow pending returns the live field.
- R8: Ready becomes 1 in the cycle after each synchronised reference update and stays 1 for READY_WIN host cycles (default 4). A status read clears it, unless a new update arrives in the same cycle.
- R9: Busy is 1 while a reference edge is still passing through the synchroniser or a load is pending, and 0 otherwise.
- R10: The seconds count wraps from 0xFFFFFFFF to 0 when the fraction chain wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ref_clk | input | 1 | 32768 Hz reference clock |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid the cycle after rd_en |

## Verification
The assertions take three things for granted about the inputs:

- A reference period spans at least three host cycles, so two synchronised updates are never adjacent.
- Reset is released away from a reference rising edge.
- Read and write strobes are plain single-cycle pulses.

The bench derives the reference clock from the host clock at 16 host cycles per period and releases reset one host cycle after a reference edge. Scenarios that need exact timing are lined up to a reference edge. All other checks poll the busy flag before they compare counts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam logic [7:0] OFF_SECONDS  = 8'h00;
   localparam logic [7:0] OFF_FRACTION = 8'h04;
   localparam logic [7:0] OFF_STATUS   = 8'h08;

   localparam int unsigned ST_BUSY  = 0;
   localparam int unsigned ST_READY = 1;

   typedef enum logic [1:0] {
      SEL_SECONDS,
      SEL_FRACTION,
      SEL_STATUS,
      SEL_NONE
   } rtc_sel_e;

   function automatic rtc_sel_e rtc_decode(input logic [7:0] offset);
      rtc_sel_e sel;
      case (offset)
         OFF_SECONDS:  sel = SEL_SECONDS;
         OFF_FRACTION: sel = SEL_FRACTION;
         OFF_STATUS:   sel = SEL_STATUS;
         default:      sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic ref_clk,
   input  logic clk,
   input  logic rst_n,
   output logic tick_o,
   output logic inflight_o
);

   initial begin
      assert (STAGES >= 2) else $error("rtc_tick_sync: STAGES must be at least 2");
   end

   // reference domain: one toggle per reference rising edge
   logic ref_tgl_q;
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) ref_tgl_q <= 1'b0;
      else        ref_tgl_q <= ~ref_tgl_q;
   end

   // host domain synchroniser and edge history
   logic [STAGES-1:0] sync_q;
   logic              seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         seen_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], ref_tgl_q};
         seen_q <= sync_q[STAGES-1];
      end
   end

   assign tick_o     = sync_q[STAGES-1] ^ seen_q;
   assign inflight_o = (sync_q != {STAGES{seen_q}});

   // R2: one reference edge gives exactly one isolated host pulse
   p_tick_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

   // R9: an update pulse is always seen as busy in the cycle that carries it
   p_tick_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> inflight_o);

endmodule

// File: rtl/rtc_count_chain.sv
module rtc_count_chain #(
   parameter int REF_HZ   = 32768,
   parameter int SUB_BITS = 12,
   parameter int SEC_W    = 32,
   parameter int FIELD_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               ld_sec_i,
   input  logic [SEC_W-1:0]   ld_sec_val_i,
   input  logic               ld_sub_i,
   input  logic [FIELD_W-1:0] ld_sub_val_i,
   output logic [SEC_W-1:0]   sec_o,
   output logic [FIELD_W-1:0] field_o
);

   localparam int SUB_HZ   = 1 << SUB_BITS;
   localparam int DIV      = REF_HZ / SUB_HZ;
   localparam int PRE_W    = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int LOW_BITS = SUB_BITS - FIELD_W;

   initial begin
      assert (REF_HZ % SUB_HZ == 0) else $error("rtc_count_chain: REF_HZ not a multiple of chain rate");
      assert (DIV >= 1)             else $error("rtc_count_chain: chain faster than reference");
      assert (LOW_BITS >= 1)        else $error("rtc_count_chain: FIELD_W must be below SUB_BITS");
      assert (SEC_W >= 1)           else $error("rtc_count_chain: SEC_W must be positive");
   end

   logic step;   // chain advances in this cycle
   logic wrap;   // chain rolls over in this cycle

   generate
      if (DIV == 1) begin : g_no_prescale
         assign step = tick_i && !ld_sub_i;
      end else begin : g_prescale
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (tick_i) begin
               if (ld_sub_i || pre_q == PRE_W'(DIV - 1)) pre_q <= '0;
               else                                     pre_q <= pre_q + 1'b1;
            end
         end
         assign step = tick_i && !ld_sub_i && (pre_q == PRE_W'(DIV - 1));
      end
   endgenerate

   logic [SUB_BITS-1:0] sub_q;
   logic [SEC_W-1:0]    sec_q;

   assign wrap = step && (&sub_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
      end else if (tick_i && ld_sub_i) begin
         sub_q <= SUB_BITS'(ld_sub_val_i) << LOW_BITS;
      end else if (step) begin
         sub_q <= sub_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
      end else if (tick_i && ld_sec_i) begin
         sec_q <= ld_sec_val_i;
      end else if (wrap) begin
         sec_q <= sec_q + 1'b1;
      end
   end

   assign sec_o   = sec_q;
   assign field_o = sub_q[SUB_BITS-1:LOW_BITS];

   // R3: chain rollover lands on zero
   p_sub_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (sub_q == '0));

   // R3, R10: seconds step by one (modulo) on every rollover without a load
   p_sec_follows_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !ld_sec_i) |=> (sec_q == $past(sec_q) + 1'b1));

   // R2: counts never move between updates
   p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ($stable(sec_q) && $stable(sub_q)));

   // R6: a fraction load clears the chain bits below the field
   p_sub_load_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && ld_sub_i) |=> (sub_q[LOW_BITS-1:0] == '0));

endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
   import rtc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int SEC_W     = 32,
   parameter int FIELD_W   = 8,
   parameter int READY_WIN = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic               tick_i,
   input  logic               sync_busy_i,
   input  logic [SEC_W-1:0]   sec_i,
   input  logic [FIELD_W-1:0] field_i,
   output logic               ld_sec_o,
   output logic [SEC_W-1:0]   ld_sec_val_o,
   output logic               ld_sub_o,
   output logic [FIELD_W-1:0] ld_sub_val_o
);

   localparam int WIN_W = $clog2(READY_WIN + 1);

   initial begin
      assert (READY_WIN >= 1)   else $error("rtc_regif: READY_WIN must be positive");
      assert (DATA_W >= SEC_W)  else $error("rtc_regif: seconds wider than data bus");
      assert (DATA_W > FIELD_W) else $error("rtc_regif: fraction field too wide");
      assert (DATA_W >= 2)      else $error("rtc_regif: status needs two bits");
   end

   rtc_sel_e sel;
   assign sel = rtc_decode(8'(addr));

   logic rd_sec, rd_sub, rd_stat, wr_sec, wr_sub;
   assign rd_sec  = rd_en && (sel == SEL_SECONDS);
   assign rd_sub  = rd_en && (sel == SEL_FRACTION);
   assign rd_stat = rd_en && (sel == SEL_STATUS);
   assign wr_sec  = wr_en && (sel == SEL_SECONDS);
   assign wr_sub  = wr_en && (sel == SEL_FRACTION);

   // pending loads, consumed by the next synchronised update
   logic               ld_sec_q, ld_sub_q;
   logic [SEC_W-1:0]   ld_sec_val_q;
   logic [FIELD_W-1:0] ld_sub_val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_sec_q     <= 1'b0;
         ld_sub_q     <= 1'b0;
         ld_sec_val_q <= '0;
         ld_sub_val_q <= '0;
      end else begin
         if (tick_i) begin
            ld_sec_q <= 1'b0;
            ld_sub_q <= 1'b0;
         end
         if (wr_sec) begin
            ld_sec_q     <= 1'b1;
            ld_sec_val_q <= wdata[SEC_W-1:0];
         end
         if (wr_sub) begin
            ld_sub_q     <= 1'b1;
            ld_sub_val_q <= wdata[FIELD_W-1:0];
         end
      end
   end

   assign ld_sec_o     = ld_sec_q;
   assign ld_sec_val_o = ld_sec_val_q;
   assign ld_sub_o     = ld_sub_q;
   assign ld_sub_val_o = ld_sub_val_q;

   // fraction shadow taken on a seconds read
   logic               sh_valid_q;
   logic [FIELD_W-1:0] sh_field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_valid_q <= 1'b0;
         sh_field_q <= '0;
      end else if (rd_sec) begin
         sh_valid_q <= 1'b1;
         sh_field_q <= field_i;
      end else if (rd_sub) begin
         sh_valid_q <= 1'b0;
      end
   end

   // ready window
   logic [WIN_W-1:0] rdy_cnt_q;
   logic             ready, busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdy_cnt_q <= '0;
      else if (tick_i)            rdy_cnt_q <= WIN_W'(READY_WIN);
      else if (rd_stat)           rdy_cnt_q <= '0;
      else if (rdy_cnt_q != '0)   rdy_cnt_q <= rdy_cnt_q - 1'b1;
   end

   assign ready = (rdy_cnt_q != '0);
   assign busy  = ld_sec_q || ld_sub_q || sync_busy_i;

   logic [DATA_W-1:0] status_word;
   always_comb begin
      status_word           = '0;
      status_word[ST_BUSY]  = busy;
      status_word[ST_READY] = ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         case (sel)
            SEL_SECONDS:  rdata <= DATA_W'(sec_i);
            SEL_FRACTION: rdata <= DATA_W'(sh_valid_q ? sh_field_q : field_i);
            SEL_STATUS:   rdata <= status_word;
            default:      rdata <= '0;
         endcase
      end
   end

   // R4: fraction word carries nothing above the field
   p_sub_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sub |=> (rdata[DATA_W-1:FIELD_W] == '0));

   // R5: busy is visible right after a seconds write
   p_busy_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sec |=> busy);

   // R8: a status read with no new update drops ready
   p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !tick_i) |=> !ready);

   // R8: each update opens the ready window
   p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> ready);

   // R7: a seconds read arms the shadow
   p_shadow_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sec |=> sh_valid_q);

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int REF_HZ      = 32768,
   parameter int SUB_BITS    = 12,
   parameter int SEC_W       = 32,
   parameter int FIELD_W     = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int READY_WIN   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_clk,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   initial begin
      assert (ADDR_W >= 4 && ADDR_W <= 8) else $error("rtc_timebase: ADDR_W out of range");
      assert (DATA_W >= SEC_W)            else $error("rtc_timebase: DATA_W below SEC_W");
   end

   logic               tick, sync_busy;
   logic               ld_sec, ld_sub;
   logic [SEC_W-1:0]   ld_sec_val, sec;
   logic [FIELD_W-1:0] ld_sub_val, field;

   rtc_tick_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .ref_clk    (ref_clk),
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_o     (tick),
      .inflight_o (sync_busy)
   );

   rtc_count_chain #(
      .REF_HZ   (REF_HZ),
      .SUB_BITS (SUB_BITS),
      .SEC_W    (SEC_W),
      .FIELD_W  (FIELD_W)
   ) u_chain (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick),
      .ld_sec_i     (ld_sec),
      .ld_sec_val_i (ld_sec_val),
      .ld_sub_i     (ld_sub),
      .ld_sub_val_i (ld_sub_val),
      .sec_o        (sec),
      .field_o      (field)
   );

   rtc_regif #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .SEC_W     (SEC_W),
      .FIELD_W   (FIELD_W),
      .READY_WIN (READY_WIN)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en        (rd_en),
      .wr_en        (wr_en),
      .addr         (addr),
      .wdata        (wdata),
      .rdata        (rdata),
      .tick_i       (tick),
      .sync_busy_i  (sync_busy),
      .sec_i        (sec),
      .field_i      (field),
      .ld_sec_o     (ld_sec),
      .ld_sec_val_o (ld_sec_val),
      .ld_sub_o     (ld_sub),
      .ld_sub_val_o (ld_sub_val)
   );

endmodule

// File: tb/test_rtc_timebase.sv
module test_rtc_timebase;

   localparam logic [3:0] A_SEC  = 4'h0;
   localparam logic [3:0] A_SUB  = 4'h4;
   localparam logic [3:0] A_STAT = 4'h8;
   localparam logic [3:0] A_NONE = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_clk = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int vectors = 0;
   int miscompares = 0;
   int ref_edges = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   // reference: 16 host cycles per period, edges on host falling edges
   always begin
      repeat (8) @(negedge clk);
      ref_clk = ~ref_clk;
   end

   always @(posedge ref_clk) ref_edges++;

   rtc_timebase i_rtc_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_clk (ref_clk),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1;
      addr  = a;
      @(negedge clk);
      rd_en = 1'b0;
      d     = rdata;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output bit idle);
      logic [31:0] d;
      idle = 1'b0;
      for (int i = 0; i < 400; i++) begin
         bus_read(A_STAT, d);
         if (!d[0]) begin
            idle = 1'b1;
            break;
         end
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      bus_read(A_SEC, d);
      check(d == 32'h0, "R1 seconds after reset", d, 32'h0);
      bus_read(A_SUB, d);
      check(d == 32'h0, "R1 fraction after reset", d, 32'h0);
      bus_read(A_STAT, d);
      check(d == 32'h0, "R1 status after reset", d, 32'h0);
      bus_read(A_NONE, d);
      check(d == 32'h0, "R4 unmapped offset reads zero", d, 32'h0);
   endtask

   task automatic t_load;
      logic [31:0] d;
      bit idle;
      bus_write(A_SEC, 32'h1234_5678);
      bus_read(A_STAT, d);
      check(d[0] == 1'b1, "R5 busy after seconds write", {31'h0, d[0]}, 32'h1);
      wait_idle(idle);
      check(idle, "R9 busy drops after load", {31'h0, idle}, 32'h1);
      bus_read(A_SEC, d);
      check(d == 32'h1234_5678, "R5 seconds loaded", d, 32'h1234_5678);
      bus_write(A_SUB, 32'hFFFF_FF80);
      bus_read(A_STAT, d);
      check(d[0] == 1'b1, "R6 busy after fraction write", {31'h0, d[0]}, 32'h1);
      wait_idle(idle);
      bus_read(A_SEC, d);
      check(d == 32'h1234_5678, "R6 seconds untouched by fraction write", d, 32'h1234_5678);
      bus_read(A_SUB, d);
      check(d == 32'h0000_0080, "R6 R4 fraction loaded, upper bits zero", d, 32'h80);
   endtask

   task automatic t_rate;
      logic [31:0] d, prev;
      int c1, c2;
      bit idle;
      bus_write(A_SUB, 32'h10);
      wait_idle(idle);
      bus_read(A_SUB, d);        // releases any pending shadow
      bus_read(A_SUB, prev);
      c1 = -1;
      c2 = -1;
      for (int i = 0; i < 6000 && c2 < 0; i++) begin
         bus_read(A_SUB, d);
         if (d != prev) begin
            if (c1 < 0) begin
               c1 = ref_edges;
               check(d == prev + 1, "R2 fraction steps by one", d, prev + 1);
            end else begin
               c2 = ref_edges;
            end
            prev = d;
         end
      end
      check(c2 - c1 >= 127 && c2 - c1 <= 129, "R2 reference edges per fraction step",
            32'(c2 - c1), 32'd128);
   endtask

   task automatic t_wrap;
      logic [31:0] s, f;
      bit idle, bad;
      bus_write(A_SEC, 32'd9);
      bus_write(A_SUB, 32'hFF);
      wait_idle(idle);
      bad = 1'b0;
      s = 32'd9;
      f = 32'hFF;
      for (int i = 0; i < 4000 && s == 32'd9; i++) begin
         bus_read(A_SEC, s);
         bus_read(A_SUB, f);
         if (s == 32'd9 && f != 32'hFF) bad = 1'b1;
      end
      check(!bad, "R3 R7 coherent pair before rollover", f, 32'hFF);
      check(s == 32'd10, "R3 seconds increment at rollover", s, 32'd10);
      check(f == 32'h0, "R3 fraction zero with new second", f, 32'h0);
   endtask

   task automatic t_rollover;
      logic [31:0] s, f;
      bit idle;
      bus_write(A_SEC, 32'hFFFF_FFFF);
      bus_write(A_SUB, 32'hFF);
      wait_idle(idle);
      s = 32'hFFFF_FFFF;
      for (int i = 0; i < 4000 && s == 32'hFFFF_FFFF; i++) bus_read(A_SEC, s);
      bus_read(A_SUB, f);
      check(s == 32'h0, "R10 seconds wrap to zero", s, 32'h0);
      check(f == 32'h0, "R10 fraction zero after wrap", f, 32'h0);
   endtask

   task automatic t_shadow;
      logic [31:0] d;
      bit idle;
      bus_write(A_SUB, 32'h20);
      wait_idle(idle);
      bus_read(A_SEC, d);
      repeat (2200) @(negedge clk);
      bus_read(A_SUB, d);
      check(d == 32'h20, "R7 fraction read returns shadow", d, 32'h20);
      bus_read(A_SUB, d);
      check(d == 32'h21, "R7 next fraction read is live", d, 32'h21);
   endtask

   task automatic t_ready;
      logic [31:0] d;
      // busy while an edge crosses the synchroniser
      @(posedge ref_clk);
      @(negedge clk);
      bus_read(A_STAT, d);
      check(d[0] == 1'b1, "R9 busy during synchroniser transit", d, 32'h1);
      // ready set after update, cleared by status read
      @(posedge ref_clk);
      repeat (3) @(negedge clk);
      bus_read(A_STAT, d);
      check(d[1] == 1'b1, "R8 ready after update", d, 32'h2);
      bus_read(A_STAT, d);
      check(d == 32'h0, "R8 ready cleared by status read", d, 32'h0);
      // window expires on its own
      @(posedge ref_clk);
      repeat (9) @(negedge clk);
      bus_read(A_STAT, d);
      check(d == 32'h0, "R8 R9 ready window expired, idle", d, 32'h0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      @(posedge ref_clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_ready();
      t_rate();
      t_wrap();
      t_shadow();
      t_rollover();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule